// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block turns a wide set of per-channel data-ready flags into one interrupt vector address. The flags arrive as two 32-bit status words that together form a single 64-entry channel ID space: word 0 carries IDs 0 to 31 and word 1 carries IDs 32 to 63. The channel with the smallest ID whose flag is set wins. Its ID is shifted left by a programmable amount of 0 to 7 positions and added to a programmable 32-bit base. The result is the address that interrupt dispatch code jumps through.

Software programs the base and the shift amount through a small register write port. The computed address and a valid flag come out of a register. They therefore follow the status words with one clock of latency. When no flag is set, the output carries the base unchanged and valid is low. Clearing the flags and the interrupt controller that uses the address are outside this block.

Top module: `irq_vec_gen`

## Requirements
- R1: While reset is asserted and right after it, the vector address and the valid output are 0, and the base and shift settings are 0. A shift of 0 means no shift.
- R2: The selected channel is the lowest-numbered set flag over the combined 64-bit space. Bit n of word 0 is ID n, and bit n of word 1 is ID 32+n.
- R3: When a flag is set, the vector address equals base + (ID << shift), for every shift value from 0 to 7.
- R4: When no flag is set, the vector address equals the programmed base.
- R5: The addition is 32 bits wide and wraps modulo 2^32 on overflow.
- R6: The outputs are registered. A change of the status words shows one clock edge later. A register write takes effect at the clock edge that captures it, so it reaches the outputs at the following edge.
- R7: A write with wr_sel=0 loads all 32 data bits into the base. A write with wr_sel=1 loads data bits [2:0] into the shift amount and ignores the other bits. Data presented while wr_en is low changes nothing.
- R8: The valid output is 1 exactly when at least one flag was set in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 selects the base, 1 selects the shift amount |
| wr_data_i | input | 32 | Write data |
| rdy_word0_i | input | 32 | Ready flags for channel IDs 0 to 31 |
| rdy_word1_i | input | 32 | Ready flags for channel IDs 32 to 63 |
| vec_addr_o | output | 32 | Registered vector address |
| vec_valid_o | output | 1 | Registered flag: some channel was ready |

## Verification
The bench builds the block with its default parameters: two 32-bit status words, a 32-bit address and a 3-bit shift. With these values the highest ID, 63, lands in the upper word, and 63 << 7 added to a base near 2^32 crosses the wrap point. The stimulus places single flags at both ends of each word and sets flags in both words at once, so that word-boundary priority is exercised. It also walks every shift value and toggles flags on consecutive cycles to expose the one-cycle latency.

// File: rtl/ivg_pkg.sv
package ivg_pkg;
  typedef enum logic {
    CFG_BASE  = 1'b0,
    CFG_SHIFT = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/ivg_rst_sync.sv
module ivg_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic stage_q, stage_d;
  logic out_q, out_d;

  always_comb begin
    stage_d = 1'b1;
    out_d   = stage_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      out_q   <= out_d;
    end
  end

  assign rst_sync_no = out_q;
endmodule

// File: rtl/ivg_cfg_regs.sv
module ivg_cfg_regs
  import ivg_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SHIFT_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [ADDR_W-1:0]  wr_data_i,
  output logic [ADDR_W-1:0]  base_o,
  output logic [SHIFT_W-1:0] shift_o
);
  logic [ADDR_W-1:0]  base_q, base_d;
  logic [SHIFT_W-1:0] shift_q, shift_d;
  logic               base_en, shift_en;

  always_comb begin
    base_en  = wr_en_i && (cfg_sel_e'(wr_sel_i) == CFG_BASE);
    shift_en = wr_en_i && (cfg_sel_e'(wr_sel_i) == CFG_SHIFT);
    base_d   = wr_data_i;
    shift_d  = wr_data_i[SHIFT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
    end else if (shift_en) begin
      shift_q <= shift_d;
    end
  end

  assign base_o  = base_q;
  assign shift_o = shift_q;

  // R7: configuration changes only under a write strobe
  assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(base_q) && $stable(shift_q)));
endmodule

// File: rtl/ivg_word_enc.sv
module ivg_word_enc #(
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] bits_i,
  output logic              any_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    any_o = |bits_i;
    idx_o = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (bits_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/ivg_prio_sel.sv
module ivg_prio_sel #(
  parameter int WORDS  = 2,
  parameter int WORD_W = 32,
  localparam int NUM_CH = WORDS * WORD_W,
  localparam int ID_W   = $clog2(NUM_CH),
  localparam int IDX_W  = $clog2(WORD_W)
) (
  input  logic [NUM_CH-1:0] rdy_i,
  output logic              any_o,
  output logic [ID_W-1:0]   id_o
);
  logic [WORDS-1:0] word_any;
  logic [IDX_W-1:0] word_idx [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    ivg_word_enc #(.WORD_W(WORD_W)) u_enc (
      .bits_i (rdy_i[w*WORD_W +: WORD_W]),
      .any_o  (word_any[w]),
      .idx_o  (word_idx[w])
    );
  end

  always_comb begin
    any_o = |word_any;
    id_o  = '0;
    for (int w = WORDS - 1; w >= 0; w--) begin
      if (word_any[w]) id_o = ID_W'(w * WORD_W) + ID_W'(word_idx[w]);
    end
  end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int SHIFT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [WORD_W-1:0] rdy_word0_i,
  input  logic [WORD_W-1:0] rdy_word1_i,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              vec_valid_o
);
  localparam int WORDS  = 2;
  localparam int NUM_CH = WORDS * WORD_W;
  localparam int ID_W   = $clog2(NUM_CH);

  logic               rst_n;
  logic [ADDR_W-1:0]  base_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [NUM_CH-1:0]  rdy_vec;
  logic               any_w;
  logic [ID_W-1:0]    id_w;
  logic [ADDR_W-1:0]  id_ext, offset, addr_d, addr_q;
  logic               valid_d, valid_q;
  logic               armed_q;

  ivg_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  ivg_cfg_regs #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .base_o    (base_q),
    .shift_o   (shift_q)
  );

  assign rdy_vec = {rdy_word1_i, rdy_word0_i};

  ivg_prio_sel #(.WORDS(WORDS), .WORD_W(WORD_W)) u_sel (
    .rdy_i (rdy_vec),
    .any_o (any_w),
    .id_o  (id_w)
  );

  always_comb begin
    id_ext  = ADDR_W'(id_w);
    offset  = id_ext << shift_q;
    valid_d = any_w;
    addr_d  = any_w ? (base_q + offset) : base_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      valid_q <= valid_d;
      armed_q <= 1'b1;
    end
  end

  assign vec_addr_o  = addr_q;
  assign vec_valid_o = valid_q;

  // R2: the chosen ID is set and no lower ID is set
  assert_prio_lowest_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    any_w |-> (rdy_vec[id_w] && ((rdy_vec & ((NUM_CH'(1) << id_w) - NUM_CH'(1))) == '0)));

  // R3: with no shift the offset above the base is the raw ID
  assert_no_shift_offset_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (armed_q && $past(any_w) && ($past(shift_q) == '0)) |->
      ((vec_addr_o - $past(base_q)) == ADDR_W'($past(id_w))));

  // R4: idle cycle returns the base unchanged
  assert_idle_base_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (armed_q && !$past(|rdy_vec)) |-> (vec_addr_o == $past(base_q)));

  // R8: valid follows the presence of any flag one cycle earlier
  assert_valid_track_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    armed_q |-> (vec_valid_o == $past(|rdy_vec)));

  // R1: outputs are clear while reset is held
  always_comb begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (vec_addr_o == '0 && !vec_valid_o);
    end
  end
endmodule

// File: tb/irq_vec_gen_tb.sv
module irq_vec_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic        wr_sel;
  logic [31:0] wr_data;
  logic [31:0] rdy0, rdy1;
  logic [31:0] vec_addr;
  logic        vec_valid;

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "R1";
  bit    done  = 1'b0;

  logic [31:0] base_m, exp_addr;
  logic [2:0]  sh_m;
  logic        exp_valid;

  always #10 clk = ~clk;

  irq_vec_gen u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .wr_sel_i    (wr_sel),
    .wr_data_i   (wr_data),
    .rdy_word0_i (rdy0),
    .rdy_word1_i (rdy1),
    .vec_addr_o  (vec_addr),
    .vec_valid_o (vec_valid)
  );

  function automatic logic [32:0] ref_vec(logic [31:0] w0, logic [31:0] w1,
                                          logic [31:0] base, logic [2:0] sh);
    int unsigned a;
    for (int i = 0; i < 64; i++) begin
      if ((i < 32) ? w0[i] : w1[i-32]) begin
        a = base + (i << sh);
        return {1'b1, a};
      end
    end
    return {1'b0, base};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_m    <= '0;
      sh_m      <= '0;
      exp_addr  <= '0;
      exp_valid <= 1'b0;
    end else begin
      {exp_valid, exp_addr} <= ref_vec(rdy0, rdy1, base_m, sh_m);
      if (wr_en) begin
        if (wr_sel) sh_m <= wr_data[2:0];
        else        base_m <= wr_data;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (vec_addr !== exp_addr) begin
        n_bad++;
        $display("FAIL %s vec_addr actual=%h expected=%h", phase, vec_addr, exp_addr);
      end
      n_cmp++;
      if (vec_valid !== exp_valid) begin
        n_bad++;
        $display("FAIL %s vec_valid actual=%b expected=%b", phase, vec_valid, exp_valid);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 32'h0;
  endtask

  task automatic flags(logic [31:0] w0, logic [31:0] w1, int hold);
    @(negedge clk);
    rdy0 = w0; rdy1 = w1;
    idle(hold);
  endtask

  task automatic wrap_up();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=finish");
    n_bad++;
    wrap_up();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; rdy0 = '0; rdy1 = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    // R1: zero shift after reset, ID 5 gives address 5
    flags(32'h20, 32'h0, 2);
    flags(32'h0, 32'h0, 1);

    phase = "R2";
    wr(1'b0, 32'h0000_1000);
    flags(32'h1, 32'h0, 2);
    flags(32'h8000_0000, 32'h0, 2);
    flags(32'h0, 32'h8000_0000, 2);
    flags(32'h80, 32'h100, 2);
    flags(32'h0, 32'h1000_0002, 2);
    flags(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2);

    phase = "R3";
    for (int s = 0; s < 8; s++) begin
      wr(1'b1, 32'(s));
      flags(32'h0, 32'h8000_0000, 2);
      flags(32'h0400_0000, 32'h0, 2);
    end

    phase = "R4";
    flags(32'h0, 32'h0, 3);
    wr(1'b0, 32'hDEAD_BEE0);
    idle(3);

    phase = "R5";
    wr(1'b0, 32'hFFFF_FFF0);
    wr(1'b1, 32'h7);
    flags(32'h0, 32'h8000_0000, 3);

    phase = "R6";
    for (int k = 0; k < 6; k++) begin
      flags(32'(k + 1), 32'(k), 0);
    end
    wr(1'b0, 32'h0000_4000);
    flags(32'h0, 32'h0, 1);

    phase = "R7";
    wr(1'b1, 32'hFFFF_FFFA);
    flags(32'h0, 32'h0000_0004, 2);
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = 32'h1234_5678;
    idle(2);
    wr_sel = 1'b1; wr_data = 32'h0000_0005;
    idle(2);
    wr_data = '0;

    phase = "R8";
    flags(32'h0, 32'h0, 2);
    flags(32'h0, 32'h1, 1);
    flags(32'h0, 32'h0, 2);

    wrap_up();
  end
endmodule